// File: doc/BRIEF.md
# Three-Register Data Stack Unit

This block is the data stack of a 16-bit stack processor. The two topmost entries live in dedicated registers, T (top) and N (next). Deeper entries live in a small register file that is addressed by an occupancy pointer. The top entry of that file is presented as N2. Each cycle the unit either accepts a 4-bit stack-permutation opcode or loads T from an external source, and it completes the operation in that same cycle.

The external load carries an ALU result or an inline literal into T and pushes the rest of the stack down. The stack permutations cover every three-deep rearrangement a stack machine's compiled code needs. These are duplicate, swap, drop, over, both rotations, nip, tuck and the two rotate-drop forms. Each one is a single register transfer across T, N and the file top.

Misuse is caught by two sticky flags. One is raised by a push into a full file and the other by a pop or top-replace on an empty file. The offending instruction is discarded. A synchronous clear empties the unit and drops both flags.

Top module: `dstk_top`

## Requirements
- R1: After asynchronous reset, or on a cycle with clr_i high (clr_i takes priority over all else), T and N become 0, the file becomes empty, and both flags become 0.
- R2: Opcode 0x0, and the unused codes 0xB to 0xF, leave T, N, N2 and the depth unchanged.
- R3: Opcode 0x1 (duplicate) gives N <= T with T kept and pushes old N. Opcode 0x4 (over) gives T <= N and N <= T, and pushes old N.
- R4: Opcode 0x2 (swap) exchanges T and N and leaves the file untouched.
- R5: Opcode 0x3 (drop) gives T <= N, N <= N2 and pops. Opcode 0x7 (nip) gives N <= N2 and pops, with T kept.
- R6: Opcode 0x5 (rotate) gives T <= N2, N <= T and file top <= old N. Opcode 0x6 (reverse rotate) gives T <= N, N <= N2 and file top <= old T. Depth is kept in both cases.
- R7: Opcode 0x8 (tuck) pushes T onto the file and keeps T and N.
- R8: Opcode 0x9 pops the file and keeps T and N. Opcode 0xA pops the file and exchanges T and N.
- R9: When ld_i is high, T <= ld_data_i, N <= old T, old N is pushed, and op_i is ignored.
- R10: A push (0x1, 0x4, 0x8 or a load) while the file holds DEPTH entries sets ovf_o and changes none of T, N, N2 or the depth.
- R11: A pop or top-replace (0x3, 0x5, 0x6, 0x7, 0x9, 0xA) on an empty file sets unf_o and changes none of T, N, N2 or the depth.
- R12: ovf_o and unf_o stay set until a clear or a reset.
- R13: n2_o shows the newest file entry, and shows 0 while the file is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear to the empty state |
| op_i | input | 4 | Stack permutation opcode |
| ld_i | input | 1 | Load T from ld_data_i with push |
| ld_data_i | input | 16 | Value for the external load |
| t_o | output | 16 | Top register T |
| n_o | output | 16 | Next register N |
| n2_o | output | 16 | Newest file entry, 0 when empty |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. T, N and the flags are registered. N2 is read combinationally from the file contents and the pointer, and both of those are registered. The bench drives each stimulus a quarter period after a rising edge and advances its queue model at the next rising edge. It then compares all five outputs a quarter period later, before the next stimulus is applied. This means a discarded or ignored instruction shows up at the ports in the very cycle it should have had no effect.

// File: rtl/dstk_pkg.sv
package dstk_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'h0,
    OP_DUP    = 4'h1,
    OP_SWAP   = 4'h2,
    OP_DROP   = 4'h3,
    OP_OVER   = 4'h4,
    OP_ROT    = 4'h5,
    OP_NROT   = 4'h6,
    OP_NIP    = 4'h7,
    OP_TUCK   = 4'h8,
    OP_RDROP  = 4'h9,
    OP_RDSWAP = 4'hA
  } stk_op_e;

  typedef enum logic [1:0] {
    MEM_HOLD = 2'd0,
    MEM_PUSH = 2'd1,
    MEM_POP  = 2'd2,
    MEM_REPL = 2'd3
  } mem_act_e;
endpackage

// File: rtl/dstk_mem.sv
module dstk_mem
  import dstk_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  mem_act_e     act_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PW-1:0] cnt_q;
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == PW'(DEPTH));
  assign top_idx = AW'(cnt_q - 1'b1);
  assign top_o   = empty_o ? '0 : mem_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      unique case (act_i)
        MEM_PUSH: if (!full_o)  cnt_q <= cnt_q + 1'b1;
        MEM_POP:  if (!empty_o) cnt_q <= cnt_q - 1'b1;
        default:  ;
      endcase
    end
  end

  // push writes slot cnt, replace rewrites slot cnt-1
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic wr_en;
    assign wr_en = !clr_i &&
                   (((act_i == MEM_PUSH) && (cnt_q == PW'(i))) ||
                    ((act_i == MEM_REPL) && (cnt_q == PW'(i + 1))));
    always_ff @(posedge clk_i) begin
      if (wr_en) mem_q[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/dstk_ctrl.sv
module dstk_ctrl
  import dstk_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] n_i,
  input  logic [W-1:0] n2_i,
  input  logic         empty_i,
  input  logic         full_i,
  output logic [W-1:0] t_nxt_o,
  output logic [W-1:0] n_nxt_o,
  output mem_act_e     act_o,
  output logic [W-1:0] wdata_o,
  output logic         ovf_ev_o,
  output logic         unf_ev_o
);
  logic need_push, need_top;

  always_comb begin
    t_nxt_o   = t_i;
    n_nxt_o   = n_i;
    act_o     = MEM_HOLD;
    wdata_o   = n_i;
    need_push = 1'b0;
    need_top  = 1'b0;
    if (ld_i) begin
      t_nxt_o   = ld_data_i;
      n_nxt_o   = t_i;
      act_o     = MEM_PUSH;
      need_push = 1'b1;
    end else begin
      case (stk_op_e'(op_i))
        OP_DUP: begin
          n_nxt_o = t_i; act_o = MEM_PUSH; need_push = 1'b1;
        end
        OP_SWAP: begin
          t_nxt_o = n_i; n_nxt_o = t_i;
        end
        OP_DROP: begin
          t_nxt_o = n_i; n_nxt_o = n2_i; act_o = MEM_POP; need_top = 1'b1;
        end
        OP_OVER: begin
          t_nxt_o = n_i; n_nxt_o = t_i; act_o = MEM_PUSH; need_push = 1'b1;
        end
        OP_ROT: begin
          t_nxt_o = n2_i; n_nxt_o = t_i; act_o = MEM_REPL; need_top = 1'b1;
        end
        OP_NROT: begin
          t_nxt_o = n_i; n_nxt_o = n2_i; act_o = MEM_REPL; wdata_o = t_i;
          need_top = 1'b1;
        end
        OP_NIP: begin
          n_nxt_o = n2_i; act_o = MEM_POP; need_top = 1'b1;
        end
        OP_TUCK: begin
          act_o = MEM_PUSH; wdata_o = t_i; need_push = 1'b1;
        end
        OP_RDROP: begin
          act_o = MEM_POP; need_top = 1'b1;
        end
        OP_RDSWAP: begin
          t_nxt_o = n_i; n_nxt_o = t_i; act_o = MEM_POP; need_top = 1'b1;
        end
        default: ;
      endcase
    end
    ovf_ev_o = need_push && full_i;
    unf_ev_o = need_top && empty_i;
    // faulted instruction is discarded whole
    if (ovf_ev_o || unf_ev_o) begin
      t_nxt_o = t_i;
      n_nxt_o = n_i;
      act_o   = MEM_HOLD;
    end
  end
endmodule

// File: rtl/dstk_top.sv
module dstk_top
  import dstk_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [3:0]   op_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_data_i,
  output logic [W-1:0] t_o,
  output logic [W-1:0] n_o,
  output logic [W-1:0] n2_o,
  output logic         ovf_o,
  output logic         unf_o
);
  logic [W-1:0] t_q, n_q, t_nxt, n_nxt, wdata, n2;
  logic         ovf_q, unf_q, ovf_ev, unf_ev, empty, full;
  mem_act_e     act;

  dstk_ctrl #(.W(W)) i_ctrl (
    .op_i     (op_i),
    .ld_i     (ld_i),
    .ld_data_i(ld_data_i),
    .t_i      (t_q),
    .n_i      (n_q),
    .n2_i     (n2),
    .empty_i  (empty),
    .full_i   (full),
    .t_nxt_o  (t_nxt),
    .n_nxt_o  (n_nxt),
    .act_o    (act),
    .wdata_o  (wdata),
    .ovf_ev_o (ovf_ev),
    .unf_ev_o (unf_ev)
  );

  dstk_mem #(.W(W), .DEPTH(DEPTH)) i_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .act_i  (act),
    .wdata_i(wdata),
    .top_o  (n2),
    .empty_o(empty),
    .full_o (full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q   <= '0;
      n_q   <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (clr_i) begin
      t_q   <= '0;
      n_q   <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      t_q   <= t_nxt;
      n_q   <= n_nxt;
      ovf_q <= ovf_q | ovf_ev;
      unf_q <= unf_q | unf_ev;
    end
  end

  assign t_o   = t_q;
  assign n_o   = n_q;
  assign n2_o  = n2;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;
endmodule

// File: rtl/dstk_chk.sv
module dstk_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic [3:0]   op_i,
  input logic         ld_i,
  input logic [W-1:0] t_o,
  input logic [W-1:0] n_o,
  input logic [W-1:0] n2_o,
  input logic         ovf_o,
  input logic         unf_o,
  input logic         full,
  input logic         empty
);
  logic push_req, top_req, live;
  assign live     = !clr_i;
  assign push_req = ld_i || op_i == 4'h1 || op_i == 4'h4 || op_i == 4'h8;
  assign top_req  = !ld_i && (op_i == 4'h3 || op_i == 4'h5 || op_i == 4'h6 ||
                              op_i == 4'h7 || op_i == 4'h9 || op_i == 4'hA);

  assert_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (t_o == '0 && n_o == '0 && n2_o == '0 && !ovf_o && !unf_o));

  assert_dup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !ld_i && op_i == 4'h1 && !full) |=>
      (t_o == $past(t_o) && n_o == $past(t_o) && n2_o == $past(n_o)));

  assert_swap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !ld_i && op_i == 4'h2) |=>
      (t_o == $past(n_o) && n_o == $past(t_o) && n2_o == $past(n2_o)));

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && push_req && full) |=>
      (ovf_o && t_o == $past(t_o) && n_o == $past(n_o) && n2_o == $past(n2_o)));

  assert_no_underflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && top_req && empty) |=>
      (unf_o && t_o == $past(t_o) && n_o == $past(n_o) && n2_o == '0));

  assert_ovf_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && ovf_o) |=> ovf_o);

  assert_unf_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && unf_o) |=> unf_o);
endmodule

bind dstk_top dstk_chk #(.W(W), .DEPTH(DEPTH)) i_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .clr_i (clr_i),
  .op_i  (op_i),
  .ld_i  (ld_i),
  .t_o   (t_o),
  .n_o   (n_o),
  .n2_o  (n2_o),
  .ovf_o (ovf_o),
  .unf_o (unf_o),
  .full  (full),
  .empty (empty)
);

// File: tb/test_dstk_top.sv
module test_dstk_top;
  localparam int PERIOD = 10;
  localparam int W      = 16;
  localparam int DEPTH  = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic [3:0]   op = 4'h0;
  logic         ld = 1'b0;
  logic [W-1:0] ld_data = '0;
  logic [W-1:0] t, n, n2;
  logic         ovf, unf;

  int checks = 0;
  int errors = 0;

  // behavioural model
  logic [W-1:0] mt = '0, mn = '0;
  logic [W-1:0] q[$];
  logic         mov = 1'b0, mun = 1'b0;
  logic         ev_ov, ev_un;

  always #(PERIOD / 2) clk = ~clk;

  dstk_top #(.W(W), .DEPTH(DEPTH)) i_dstk_top (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .clr_i    (clr),
    .op_i     (op),
    .ld_i     (ld),
    .ld_data_i(ld_data),
    .t_o      (t),
    .n_o      (n),
    .n2_o     (n2),
    .ovf_o    (ovf),
    .unf_o    (unf)
  );

  function automatic string tag_of(logic c, logic l, logic [3:0] o);
    if (c) return "R1";
    if (l) return "R9";
    case (o)
      4'h1, 4'h4: return "R3";
      4'h2:       return "R4";
      4'h3, 4'h7: return "R5";
      4'h5, 4'h6: return "R6";
      4'h8:       return "R7";
      4'h9, 4'hA: return "R8";
      default:    return "R2";
    endcase
  endfunction

  task automatic model_step(logic c, logic l, logic [3:0] o, logic [W-1:0] d);
    logic [W-1:0] tmp;
    ev_ov = 1'b0;
    ev_un = 1'b0;
    if (c) begin
      mt = '0; mn = '0; q.delete(); mov = 1'b0; mun = 1'b0;
      return;
    end
    if (l || o == 4'h1 || o == 4'h4 || o == 4'h8) begin
      if (q.size() == DEPTH) begin ev_ov = 1'b1; mov = 1'b1; return; end
    end
    if (!l && (o == 4'h3 || o == 4'h5 || o == 4'h6 || o == 4'h7 ||
               o == 4'h9 || o == 4'hA)) begin
      if (q.size() == 0) begin ev_un = 1'b1; mun = 1'b1; return; end
    end
    if (l) begin
      q.push_back(mn); mn = mt; mt = d;
      return;
    end
    case (o)
      4'h1: begin q.push_back(mn); mn = mt; end
      4'h2: begin tmp = mt; mt = mn; mn = tmp; end
      4'h3: begin mt = mn; mn = q.pop_back(); end
      4'h4: begin q.push_back(mn); tmp = mt; mt = mn; mn = tmp; end
      4'h5: begin tmp = q[$]; q[$] = mn; mn = mt; mt = tmp; end
      4'h6: begin tmp = q[$]; q[$] = mt; mt = mn; mn = tmp; end
      4'h7: begin mn = q.pop_back(); end
      4'h8: begin q.push_back(mt); end
      4'h9: begin void'(q.pop_back()); end
      4'hA: begin void'(q.pop_back()); tmp = mt; mt = mn; mn = tmp; end
      default: ;
    endcase
  endtask

  task automatic compare(string tag);
    logic [W-1:0] exp_n2;
    string ftag;
    exp_n2 = (q.size() > 0) ? q[$] : '0;
    checks++;
    if (t !== mt || n !== mn) begin
      errors++;
      $display("FAIL %s T/N actual %h/%h expected %h/%h", tag, t, n, mt, mn);
    end
    checks++;
    if (n2 !== exp_n2) begin
      errors++;
      $display("FAIL R13 (%s) N2 actual %h expected %h", tag, n2, exp_n2);
    end
    ftag = ev_ov ? "R10" : (ev_un ? "R11" : "R12");
    checks++;
    if (ovf !== mov || unf !== mun) begin
      errors++;
      $display("FAIL %s flags actual ovf=%b unf=%b expected ovf=%b unf=%b",
               ftag, ovf, unf, mov, mun);
    end
  endtask

  task automatic step(logic c, logic l, logic [3:0] o, logic [W-1:0] d);
    clr = c; ld = l; op = o; ld_data = d;
    @(posedge clk);
    model_step(c, l, o, d);
    #(PERIOD / 4);
    compare(tag_of(c, l, o));
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    ev_ov = 1'b0;
    ev_un = 1'b0;
    #(PERIOD * 2 + 1);
    compare("R1");
    rst_n = 1'b1;
    @(posedge clk);
    #(PERIOD / 4);

    // directed: build a few entries, then every opcode once
    step(1'b0, 1'b1, 4'h0, 16'h1111);
    step(1'b0, 1'b1, 4'h0, 16'h2222);
    step(1'b0, 1'b1, 4'h0, 16'h3333);
    step(1'b0, 1'b1, 4'h0, 16'h4444);
    for (int o = 0; o < 16; o++) begin
      step(1'b0, 1'b1, 4'h0, 16'hA000 + 16'(o));
      step(1'b0, 1'b0, 4'(o), 16'hFFFF);
    end

    // R10: fill to full then overflow twice
    for (int i = 0; i < DEPTH + 3; i++) step(1'b0, 1'b1, 4'h0, 16'h5000 + 16'(i));
    step(1'b0, 1'b0, 4'h1, '0);
    step(1'b0, 1'b0, 4'h8, '0);
    step(1'b0, 1'b0, 4'h5, '0);
    step(1'b0, 1'b0, 4'h6, '0);
    // R1: clear with a load pending
    step(1'b1, 1'b1, 4'h1, 16'hDEAD);
    // R11: pops and replaces on empty file
    step(1'b0, 1'b0, 4'h3, '0);
    step(1'b0, 1'b0, 4'h5, '0);
    step(1'b0, 1'b0, 4'hA, '0);
    step(1'b0, 1'b0, 4'h2, '0);
    step(1'b1, 1'b0, 4'h0, '0);
    // R9: load overrides opcode
    step(1'b0, 1'b1, 4'h2, 16'hBEEF);
    step(1'b0, 1'b1, 4'h3, 16'hCAFE);

    // pseudo-random mix
    seed = 32'h1234_5678;
    for (int i = 0; i < 800; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      step(seed[29:24] == 6'd0, seed[22:20] == 3'd0, seed[19:16], seed[15:0]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule